// File: doc/BRIEF.md
# Segmented Scaled-Index Address Generator

This block forms the linear address of a memory operation. Each request adds four terms: a base register value, an index register value shifted left by a scale, a displacement immediate and a segment base. Base and index come from register-file read ports. The scale and the displacement come from the decoded instruction, so the scale acts as a fixed left shift and never as a shift amount read from a register. The segment base is usually zero, but it is always accepted and added.

The terms are built in parallel: the base and index are gated when the addressing mode omits them, the index is shifted, and the displacement is sign-extended. A chain of 3:2 carry-save compressors reduces the four terms to two vectors, and one carry-propagate adder produces the result. That result is captured in an output register, and a valid flag is raised in the cycle after the request. The datapath only adds. It has no memory indirection and no register update. Address translation and memory access belong to the stages that follow this block.

Top module: `agen_top`

## Requirements
- R1: When a request is accepted, `addr_out` becomes base + (index << scale) + displacement + segment base. For example, base 0x1000, index 5, scale 2 and displacement 8 give 0x101C.
- R2: `scale_sel` encodes the index multiplier. 0 multiplies by 1, 1 by 2, 2 by 4 and 3 by 8.
- R3: When `disp_is_byte`=1, only `disp_imm[7:0]` is used, sign-extended from bit 7, and bits 31:8 have no effect. When `disp_is_byte`=0, all 32 bits of `disp_imm` are used.
- R4: When `base_en`=0, the base term is zero whatever the value of `base_val`.
- R5: When `index_en`=0, the index term is zero whatever the values of `index_val` and `scale_sel`.
- R6: `seg_base` is always added, including when it is nonzero.
- R7: All arithmetic wraps modulo 2^32. Carries out of bit 31 are discarded and no overflow is signalled.
- R8: `addr_vld` is 1 in exactly the cycle after each cycle in which `req_vld`=1, and it is 0 otherwise. Requests in back-to-back cycles each produce their own result.
- R9: While reset is asserted, and until the first request after reset, `addr_vld` is 0.
- R10: In a cycle without a request, `addr_out` keeps its previous value, and the operand inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_vld | input | 1 | Request strobe: an address is computed this cycle |
| base_en | input | 1 | The addressing mode includes the base term |
| base_val | input | 32 | Base value from a register-file read |
| index_en | input | 1 | The addressing mode includes the index term |
| index_val | input | 32 | Index value from a register-file read |
| scale_sel | input | 2 | Index shift: 0..3, a multiply by 1, 2, 4 or 8 |
| disp_imm | input | 32 | Displacement immediate from the decoder |
| disp_is_byte | input | 1 | 1: the displacement is the sign-extended 8-bit field |
| seg_base | input | 32 | Segment base value |
| addr_vld | output | 1 | Result valid, one cycle after the request |
| addr_out | output | 32 | Linear address |

## Verification
Every result is due exactly one clock edge after its request. The edge that samples `req_vld` also loads the output register, so there is no extra stage to count. The driver applies each request on a falling edge and pushes the expected sum into a queue. The monitor samples one nanosecond after each rising edge. At that point the queue must hold an item exactly when `addr_vld` is 1, and `addr_out` must match the item it pops. In cycles without a result, the monitor checks that `addr_out` has not moved, while the driver puts unrelated values on the operand inputs.

// File: rtl/agen_pkg.sv
package agen_pkg;
  parameter int unsigned AW        = 32;
  parameter int unsigned SCALE_W   = 2;
  parameter int unsigned SHORT_W   = 8;
  parameter int unsigned NUM_TERMS = 4;

  typedef logic [AW-1:0] addr_t;

  typedef enum logic [SCALE_W-1:0] {
    SC_X1 = 2'd0,
    SC_X2 = 2'd1,
    SC_X4 = 2'd2,
    SC_X8 = 2'd3
  } scale_e;

  // Position of each term in the operand vector fed to the tree
  localparam int unsigned T_BASE  = 0;
  localparam int unsigned T_INDEX = 1;
  localparam int unsigned T_DISP  = 2;
  localparam int unsigned T_SEG   = 3;
endpackage

// File: rtl/agen_rst_sync.sv
module agen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/agen_operand_sel.sv
module agen_operand_sel
  import agen_pkg::*;
#(
  parameter int unsigned W      = AW,
  parameter int unsigned SW     = SCALE_W,
  parameter int unsigned DSHORT = SHORT_W
) (
  input  logic                    base_en,
  input  logic [W-1:0]            base_val,
  input  logic                    index_en,
  input  logic [W-1:0]            index_val,
  input  logic [SW-1:0]           scale_sel,
  input  logic [W-1:0]            disp_imm,
  input  logic                    disp_is_byte,
  input  logic [W-1:0]            seg_base,
  output logic [NUM_TERMS-1:0][W-1:0] terms
);
  localparam int unsigned NSCALE = 1 << SW;

  logic [W-1:0]        base_term;
  logic [W-1:0]        index_gated;
  logic [W-1:0]        index_term;
  logic [W-1:0]        disp_term;
  logic [NSCALE-1:0][W-1:0] shift_opts;

  always_comb begin
    base_term   = base_en  ? base_val  : '0;
    index_gated = index_en ? index_val : '0;
  end

  // One hard-wired shift per scale encoding, then a mux
  for (genvar s = 0; s < NSCALE; s++) begin : g_shift
    if (s == 0) begin : g_id
      assign shift_opts[s] = index_gated;
    end else begin : g_sh
      assign shift_opts[s] = {index_gated[W-1-s:0], {s{1'b0}}};
    end
  end

  always_comb begin
    index_term = shift_opts[scale_sel];
  end

  // Short displacement: sign-extend the low field
  always_comb begin
    if (disp_is_byte)
      disp_term = {{(W-DSHORT){disp_imm[DSHORT-1]}}, disp_imm[DSHORT-1:0]};
    else
      disp_term = disp_imm;
  end

  always_comb begin
    terms          = '0;
    terms[T_BASE]  = base_term;
    terms[T_INDEX] = index_term;
    terms[T_DISP]  = disp_term;
    terms[T_SEG]   = seg_base;
  end
endmodule

// File: rtl/agen_csa3.sv
module agen_csa3 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] maj;

  always_comb begin
    sum_o   = in_a ^ in_b ^ in_c;
    maj     = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
    // Carry weight is one position up; bit W-1 leaves the word (mod 2^W)
    carry_o = {maj[W-2:0], 1'b0};
  end
endmodule

// File: rtl/agen_csa_tree.sv
module agen_csa_tree
  import agen_pkg::*;
#(
  parameter int unsigned W  = AW,
  parameter int unsigned NT = NUM_TERMS
) (
  input  logic [NT-1:0][W-1:0] terms,
  output logic [W-1:0]         vec_s,
  output logic [W-1:0]         vec_c
);
  localparam int unsigned NCSA = NT - 2;

  logic [NCSA:0][W-1:0] acc_s;
  logic [NCSA:0][W-1:0] acc_c;

  assign acc_s[0] = terms[0];
  assign acc_c[0] = terms[1];

  // Each stage folds one further term into the redundant pair
  for (genvar k = 0; k < NCSA; k++) begin : g_stage
    agen_csa3 #(.W(W)) i_csa (
      .in_a    (acc_s[k]),
      .in_b    (acc_c[k]),
      .in_c    (terms[k+2]),
      .sum_o   (acc_s[k+1]),
      .carry_o (acc_c[k+1])
    );
  end

  assign vec_s = acc_s[NCSA];
  assign vec_c = acc_c[NCSA];
endmodule

// File: rtl/agen_cpa.sv
module agen_cpa #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] result
);
  logic [W:0] full;

  always_comb begin
    full   = {1'b0, op_a} + {1'b0, op_b};
    result = full[W-1:0];
  end
endmodule

// File: rtl/agen_top.sv
module agen_top
  import agen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              base_en,
  input  logic [AW-1:0]     base_val,
  input  logic              index_en,
  input  logic [AW-1:0]     index_val,
  input  logic [SCALE_W-1:0] scale_sel,
  input  logic [AW-1:0]     disp_imm,
  input  logic              disp_is_byte,
  input  logic [AW-1:0]     seg_base,
  output logic              addr_vld,
  output logic [AW-1:0]     addr_out
);
  logic                         rst_sync_n;
  logic [NUM_TERMS-1:0][AW-1:0] terms;
  logic [AW-1:0]                red_s;
  logic [AW-1:0]                red_c;
  logic [AW-1:0]                sum_w;
  logic [AW-1:0]                addr_d, addr_q;
  logic                         vld_d, vld_q;

  agen_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  agen_operand_sel #(.W(AW), .SW(SCALE_W), .DSHORT(SHORT_W)) i_opsel (
    .base_en      (base_en),
    .base_val     (base_val),
    .index_en     (index_en),
    .index_val    (index_val),
    .scale_sel    (scale_sel),
    .disp_imm     (disp_imm),
    .disp_is_byte (disp_is_byte),
    .seg_base     (seg_base),
    .terms        (terms)
  );

  agen_csa_tree #(.W(AW), .NT(NUM_TERMS)) i_tree (
    .terms (terms),
    .vec_s (red_s),
    .vec_c (red_c)
  );

  agen_cpa #(.W(AW)) i_cpa (
    .op_a   (red_s),
    .op_b   (red_c),
    .result (sum_w)
  );

  // Next-state: load on request, hold otherwise
  always_comb begin
    vld_d  = req_vld;
    addr_d = req_vld ? sum_w : addr_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_d;
  end

  assign addr_vld = vld_q;
  assign addr_out = addr_q;

  // R1: the redundant pair from the tree carries the full four-term sum
  a_r1_two_vector_sum: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_vld |-> ((red_s + red_c) ==
                 (terms[T_BASE] + terms[T_INDEX] + terms[T_DISP] + terms[T_SEG])));

  // R2: a scaled index never has bits set below the shift amount
  a_r2_scaled_low_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_vld |-> ((terms[T_INDEX] & ((AW'(1) << scale_sel) - AW'(1))) == '0));

  // R8: a request yields a valid result in the following cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_vld |=> addr_vld);

  // R8: no result without a request
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_vld |=> !addr_vld);

  // R10: the address holds through idle cycles
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_vld |=> $stable(addr_out));
endmodule

// File: tb/test_agen_top.sv
module test_agen_top;
  logic        clk;
  logic        rst_n;
  logic        req_vld;
  logic        base_en;
  logic [31:0] base_val;
  logic        index_en;
  logic [31:0] index_val;
  logic [1:0]  scale_sel;
  logic [31:0] disp_imm;
  logic        disp_is_byte;
  logic [31:0] seg_base;
  logic        addr_vld;
  logic [31:0] addr_out;

  typedef struct {
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks;
  int          n_fail;
  bit          mon_on;
  bit          ended;
  logic [31:0] last_addr;
  bit          have_last;

  agen_top i_agen_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_vld      (req_vld),
    .base_en      (base_en),
    .base_val     (base_val),
    .index_en     (index_en),
    .index_val    (index_val),
    .scale_sel    (scale_sel),
    .disp_imm     (disp_imm),
    .disp_is_byte (disp_is_byte),
    .seg_base     (seg_base),
    .addr_vld     (addr_vld),
    .addr_out     (addr_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] model(input logic be, input logic [31:0] b,
                                        input logic ie, input logic [31:0] ix,
                                        input logic [1:0] sc, input logic [31:0] d,
                                        input logic byte_d, input logic [31:0] sg);
    logic [31:0] bt, it, dt;
    bt = be ? b : 32'd0;
    it = ie ? (ix * (32'd1 << sc)) : 32'd0;
    dt = byte_d ? {{24{d[7]}}, d[7:0]} : d;
    return bt + it + dt + sg;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic issue(input string tag, input logic be, input logic [31:0] b,
                       input logic ie, input logic [31:0] ix, input logic [1:0] sc,
                       input logic [31:0] d, input logic byte_d, input logic [31:0] sg);
    exp_t e;
    @(negedge clk);
    req_vld = 1'b1;  base_en = be;  base_val = b;  index_en = ie;
    index_val = ix;  scale_sel = sc;  disp_imm = d;  disp_is_byte = byte_d;
    seg_base = sg;
    e.addr = model(be, b, ie, ix, sc, d, byte_d, sg);
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // Idle cycle with unrelated operand values (R10)
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_vld = 1'b0;
      base_en = 1'b1;  base_val = $urandom;  index_en = 1'b1;
      index_val = $urandom;  scale_sel = 2'($urandom);  disp_imm = $urandom;
      disp_is_byte = 1'($urandom);  seg_base = $urandom;
    end
  endtask

  // Monitor: pops the scoreboard one edge after each request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        check(addr_vld == (sb_q.size() != 0), "R8 valid timing",
              {31'd0, addr_vld}, {31'd0, sb_q.size() != 0});
        if (addr_vld && sb_q.size() != 0) begin
          exp_t e;
          e = sb_q.pop_front();
          check(addr_out === e.addr, e.tag, addr_out, e.addr);
          last_addr = addr_out;
          have_last = 1'b1;
        end else if (!addr_vld && have_last) begin
          check(addr_out === last_addr, "R10 hold when idle", addr_out, last_addr);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0;  n_fail = 0;  mon_on = 1'b0;  ended = 1'b0;  have_last = 1'b0;
    last_addr = '0;
    rst_n = 1'b0;  req_vld = 1'b0;  base_en = 1'b0;  base_val = '0;
    index_en = 1'b0;  index_val = '0;  scale_sel = '0;  disp_imm = '0;
    disp_is_byte = 1'b0;  seg_base = '0;

    repeat (3) @(posedge clk);
    #1;
    check(addr_vld == 1'b0, "R9 valid low in reset", {31'd0, addr_vld}, 32'd0);
    @(negedge clk);
    req_vld = 1'b1;           // request during reset must not leak out
    @(posedge clk);
    #1;
    check(addr_vld == 1'b0, "R9 request ignored in reset", {31'd0, addr_vld}, 32'd0);
    @(negedge clk);
    req_vld = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(addr_vld == 1'b0, "R9 valid low after reset", {31'd0, addr_vld}, 32'd0);
    mon_on = 1'b1;

    // R1 representative: base + 4*index + 8
    issue("R1 base+4*idx+8", 1, 32'h0000_1000, 1, 32'd5, 2'd2, 32'd8, 1, 32'd0);
    idle(2);
    // R2 each scale, back-to-back (R8)
    for (int s = 0; s < 4; s++)
      issue("R2 scale encoding", 1, 32'h0000_0100, 1, 32'h11, 2'(s), 32'd0, 0, 32'd0);
    idle(1);
    // R3 short displacement with junk upper bits, then full width
    issue("R3 short disp negative", 1, 32'h0000_2000, 0, 32'd0, 2'd0, 32'h1234_5680, 1, 32'd0);
    issue("R3 short disp positive", 1, 32'h0000_2000, 0, 32'd0, 2'd0, 32'hABCD_EF7F, 1, 32'd0);
    issue("R3 full disp", 1, 32'h0000_2000, 0, 32'd0, 2'd0, 32'h1234_5680, 0, 32'd0);
    idle(3);
    // R4 base omitted
    issue("R4 base disabled", 0, 32'hDEAD_BEEF, 1, 32'd3, 2'd3, 32'd16, 1, 32'd0);
    // R5 index omitted
    issue("R5 index disabled", 1, 32'h0000_4000, 0, 32'hFFFF_0000, 2'd3, 32'd4, 1, 32'd0);
    // R6 nonzero segment base
    issue("R6 segment added", 1, 32'h0000_0040, 1, 32'd2, 2'd1, 32'hFFFF_FFFC, 0, 32'h0040_0000);
    idle(1);
    // R7 wrap-around
    issue("R7 wrap all ones", 1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 2'd3, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF);
    issue("R7 wrap to zero", 1, 32'h8000_0000, 1, 32'h4000_0000, 2'd1, 32'd0, 0, 32'd0);
    idle(2);
    // Mixed patterns with gaps
    for (int k = 0; k < 200; k++) begin
      issue("R1 mixed operands", 1'($urandom), $urandom, 1'($urandom), $urandom,
            2'($urandom), $urandom, 1'($urandom), ($urandom % 4 == 0) ? $urandom : 32'd0);
      if (k % 5 == 0) idle(1 + k % 3);
    end
    idle(3);
    check(sb_q.size() == 0, "R8 all results delivered", sb_q.size(), 32'd0);
    finish_run();
  end
endmodule